// File: doc/BRIEF.md
# Programmable Multiplier Watchdog

This block is a one-shot watchdog. It is programmed through a single byte register. The byte sets the timeout as a multiplier scaled by a power of four, and a steering bit picks what happens when the timeout runs out. The counter advances only on strobes from an external 16 Hz time base, so one tick is one sixteenth of a second. That time base is not part of this block.

Software keeps the watchdog alive by accessing its register. A write stores a new setting and restarts the countdown with it. A read restarts the countdown with the stored setting. When a countdown runs out, the block raises a sticky expiry flag and takes one of two actions:

- It emits a one-cycle interrupt pulse.
- It requests a system reset. In this case it also wipes its own register to zero and pulses a clear strobe to a century bit that lives in a neighbouring register.

After either action the watchdog stays idle until the next access.

Top module: `multres_watchdog`

## Requirements
- R1: After reset the register reads 0x00, the flag, interrupt, reset-request and century-clear outputs are all 0, and the watchdog is idle.
- R2: Register bits [1:0] hold a resolution code r, bits [6:2] hold a multiplier m, and bit 7 is the steering bit. The timeout is m × 4^r ticks. Expiry happens on exactly that tick counted after the restart, and never on an earlier one.
- R3: A setting whose timeout is zero never expires, and ticks are ignored. This covers the value 0x00 and any value with m = 0, such as 0x03. Ticks that arrive while the watchdog is idle are also ignored.
- R4: A write stores the data byte, which appears on reg_rdata in the next cycle. It also restarts the countdown with the new timeout, and any count in progress is discarded.
- R5: A read restarts the countdown using the stored setting.
- R6: Any write or read clears the flag.
- R7: The flag rises in the cycle after the final tick. Once expired, the watchdog produces no further action until it is restarted.
- R8: On expiry with bit 7 = 1, reset_req and century_clr each pulse high for exactly one cycle, the register becomes 0x00 in that same cycle, and no interrupt is given.
- R9: On expiry with bit 7 = 0, irq pulses high for exactly one cycle, the register keeps its value, and neither reset_req nor century_clr is asserted.
- R10: An access in the same cycle as the final tick takes priority. No expiry occurs, and the countdown reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at 16 Hz |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Register read strobe (restarts the countdown) |
| reg_rdata | output | 8 | Current register value |
| wd_flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | One-cycle expiry interrupt pulse |
| reset_req | output | 1 | One-cycle system reset request |
| century_clr | output | 1 | One-cycle clear strobe for the external century bit |

## Verification
The assertions take tick, reg_wr and reg_rd to be synchronous to clk and free of X once reset has ended. They also assume that a write's data is valid in the cycle of its strobe. They place no limit on how often the strobes may occur, so an access may coincide with any tick.

The stimulus changes inputs only on the falling clock edge and holds each strobe for one cycle. Random multipliers are capped at the largest resolution code so that each trial stays short. Directed cases force the same-cycle access-and-tick collision, zero-multiplier settings and restarts in mid-count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_RES_W  = 2;
  localparam int unsigned WDT_MULT_W = 5;

  typedef enum logic [1:0] {
    WDT_ACT_NONE  = 2'd0,
    WDT_ACT_IRQ   = 2'd1,
    WDT_ACT_RESET = 2'd2
  } wdt_act_e;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             wipe,
  output logic [REG_W-1:0] value
);
  // A write takes priority over a wipe (the wipe is suppressed on a restart anyway).
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (wr)   value <= wdata;
    else if (wipe) value <= '0;
  end
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int unsigned RES_W  = 2,
  parameter int unsigned MULT_W = 5,
  parameter int unsigned CNT_W  = 11
) (
  input  logic [RES_W-1:0]  res,
  input  logic [MULT_W-1:0] mult,
  output logic [CNT_W-1:0]  ticks
);
  localparam int unsigned SH_W = RES_W + 1;

  logic [SH_W-1:0] shamt;

  // Scaling by 4^res is a left shift of the multiplier by 2*res.
  assign shamt = {res, 1'b0};
  assign ticks = CNT_W'(mult) << shamt;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] load,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             armed;

  // Expiry is the final tick of an armed count; a restart in the same cycle overrides it.
  assign expire = armed & tick & (cnt == CNT_W'(1)) & ~restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= load;
      armed <= (load != '0);
    end else if (armed && tick) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic expire,
  input  logic steer,
  output logic flag,
  output logic irq,
  output logic reset_req,
  output logic century_clr
);
  wdt_act_e act;

  always_comb begin
    act = WDT_ACT_NONE;
    if (expire) act = steer ? WDT_ACT_RESET : WDT_ACT_IRQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag        <= 1'b0;
      irq         <= 1'b0;
      reset_req   <= 1'b0;
      century_clr <= 1'b0;
    end else begin
      irq         <= (act == WDT_ACT_IRQ);
      reset_req   <= (act == WDT_ACT_RESET);
      century_clr <= (act == WDT_ACT_RESET);
      if (restart)     flag <= 1'b0;
      else if (expire) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/multres_watchdog.sv
module multres_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned RES_W  = WDT_RES_W,
  parameter int unsigned MULT_W = WDT_MULT_W,
  localparam int unsigned REG_W     = RES_W + MULT_W + 1,
  localparam int unsigned MAX_TICKS = ((1 << MULT_W) - 1) << (2 * ((1 << RES_W) - 1)),
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wd_flag,
  output logic             irq,
  output logic             reset_req,
  output logic             century_clr
);
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] load_val;
  logic [CNT_W-1:0] load_ticks;
  logic             restart;
  logic             expire;
  logic             steer;

  assign restart  = reg_wr | reg_rd;
  // A write restarts with the incoming value, a read with the stored one.
  assign load_val = reg_wr ? reg_wdata : cfg_q;
  assign steer    = cfg_q[REG_W-1];

  wdt_cfg_reg #(.REG_W(REG_W)) cfg_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .wipe  (expire & steer),
    .value (cfg_q)
  );

  wdt_interval #(.RES_W(RES_W), .MULT_W(MULT_W), .CNT_W(CNT_W)) ivl_i (
    .res   (load_val[RES_W-1:0]),
    .mult  (load_val[RES_W +: MULT_W]),
    .ticks (load_ticks)
  );

  wdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .restart (restart),
    .load    (load_ticks),
    .expire  (expire)
  );

  wdt_action act_i (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .expire      (expire),
    .steer       (steer),
    .flag        (wd_flag),
    .irq         (irq),
    .reset_req   (reset_req),
    .century_clr (century_clr)
  );

  assign reg_rdata = cfg_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             wd_flag,
  input logic             irq,
  input logic             reset_req,
  input logic             century_clr
);
  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  a_r8_no_irq_with_reset: assert property (@(posedge clk) disable iff (rst)
    !(reset_req && irq));

  a_r8_reg_wiped: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (reg_rdata == '0));

  a_r8_century_one_cycle: assert property (@(posedge clk) disable iff (rst)
    century_clr |=> !century_clr);

  a_r9_reg_kept: assert property (@(posedge clk) disable iff (rst)
    irq |-> $stable(reg_rdata));

  a_r7_flag_with_action: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_flag) |-> (irq || reset_req));

  a_r6_access_clears_flag: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |=> !wd_flag);

  a_r4_write_stores: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));
endmodule

bind multres_watchdog wdt_checker #(.REG_W(REG_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .wd_flag     (wd_flag),
  .irq         (irq),
  .reset_req   (reset_req),
  .century_clr (century_clr)
);

// File: tb/multres_watchdog_tb_top.sv
`timescale 1ns/1ps
module multres_watchdog_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       wd_flag, irq, reset_req, century_clr;

  int checks = 0;
  int errors = 0;
  int irq_n = 0, rst_n = 0, cent_n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  multres_watchdog dut_i (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .wd_flag(wd_flag), .irq(irq),
    .reset_req(reset_req), .century_clr(century_clr)
  );

  // Pulse counters sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (irq)         irq_n++;
      if (reset_req)   rst_n++;
      if (century_clr) cent_n++;
    end
  end

  function automatic int exp_ticks(input logic [7:0] v);
    return (1 << (2 * int'(v[1:0]))) * int'(v[6:2]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = v; end
    @(negedge clk) reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) reg_rd = 1'b1;
    @(negedge clk) reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_with_tick();
    @(negedge clk) begin reg_rd = 1'b1; tick = 1'b1; end
    @(negedge clk) begin reg_rd = 1'b0; tick = 1'b0; end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int i0, r0, c0, n;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(reg_rdata == 8'h00, "R1", "reg after reset", reg_rdata, 0);
    check({wd_flag, irq, reset_req, century_clr} == 4'b0, "R1", "outputs after reset",
          {wd_flag, irq, reset_req, century_clr}, 0);
    // R3 ticks while idle are ignored
    do_tick(5);
    check(wd_flag == 1'b0 && irq_n == 0 && rst_n == 0, "R3", "idle ticks", wd_flag, 0);

    // R3 zero value and zero multiplier
    do_write(8'h00);
    do_tick(20);
    check(wd_flag == 1'b0 && irq_n == 0, "R3", "value 0x00 expired", wd_flag, 0);
    do_write(8'h03);
    do_tick(80);
    check(wd_flag == 1'b0 && irq_n == 0, "R3", "mult zero expired", wd_flag, 0);

    // R5 read restarts with stored value (0x05: r=1 m=1 -> 4 ticks)
    do_write(8'h05);
    do_tick(3);
    do_read();
    do_tick(3);
    check(wd_flag == 1'b0, "R5", "flag after read restart + 3 ticks", wd_flag, 0);
    do_tick(1);
    check(wd_flag == 1'b1 && irq_n == 1, "R5", "expiry after 4 ticks", irq_n, 1);

    // R6 write clears flag; R4 write mid-count replaces interval
    do_write(8'h08);   // 2 ticks
    check(wd_flag == 1'b0, "R6", "flag after write", wd_flag, 0);
    do_tick(1);
    do_write(8'h0C);   // 3 ticks
    check(reg_rdata == 8'h0C, "R4", "stored value", reg_rdata, 8'h0C);
    do_tick(2);
    check(wd_flag == 1'b0, "R4", "old interval expired", wd_flag, 0);
    do_tick(1);
    check(wd_flag == 1'b1, "R4", "new interval expiry", wd_flag, 1);

    // R10 access in same cycle as final tick wins (0x04: 1 tick)
    do_write(8'h04);
    i0 = irq_n;
    read_with_tick();
    check(wd_flag == 1'b0 && irq_n == i0, "R10", "expiry despite access", irq_n - i0, 0);
    do_tick(1);
    check(wd_flag == 1'b1 && irq_n == i0 + 1, "R10", "reloaded count expiry", irq_n - i0, 1);

    // R8 directed steer expiry (0x84: 1 tick, reset)
    do_write(8'h84);
    r0 = rst_n; c0 = cent_n; i0 = irq_n;
    do_tick(1);
    check(rst_n == r0 + 1 && cent_n == c0 + 1 && irq_n == i0, "R8", "reset action",
          rst_n - r0, 1);
    check(reg_rdata == 8'h00, "R8", "reg wiped", reg_rdata, 0);

    // Random trials: R2 R7 R8 R9 R6
    for (int t = 0; t < 14; t++) begin
      v[1:0] = 2'($urandom % 4);
      v[6:2] = (v[1:0] == 2'd3) ? 5'(1 + $urandom % 6) : 5'(1 + $urandom % 31);
      v[7]   = 1'($urandom % 2);
      n = exp_ticks(v);
      do_write(v);
      check(reg_rdata == v, "R4", "random stored value", reg_rdata, v);
      do_tick(n - 1);
      check(wd_flag == 1'b0, "R2", "flag before final tick", wd_flag, 0);
      i0 = irq_n; r0 = rst_n; c0 = cent_n;
      do_tick(1);
      check(wd_flag == 1'b1, "R2", "flag on final tick", wd_flag, 1);
      if (v[7]) begin
        check(rst_n == r0 + 1 && cent_n == c0 + 1 && irq_n == i0, "R8", "steered reset",
              rst_n - r0, 1);
        check(reg_rdata == 8'h00, "R8", "random reg wiped", reg_rdata, 0);
      end else begin
        check(irq_n == i0 + 1 && rst_n == r0 && cent_n == c0, "R9", "steered irq",
              irq_n - i0, 1);
        check(reg_rdata == v, "R9", "reg retained", reg_rdata, v);
      end
      i0 = irq_n; r0 = rst_n;
      do_tick(2);
      check(irq_n == i0 && rst_n == r0 && wd_flag == 1'b1, "R7", "one-shot",
            irq_n - i0 + rst_n - r0, 0);
      do_read();
      check(wd_flag == 1'b0, "R6", "read clears flag", wd_flag, 0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule